// File: doc/BRIEF.md
# Disk Sector Word Buffer with Serial Conversion

This block buffers 16-bit words between a bit-serial disk channel and the memory side of a disk controller. It holds up to 256 words in first-in first-out order. In the from-disk direction, an internal deserializer collects one bit on each bit-enable pulse and writes every finished word into the buffer. In the to-disk direction, an internal serializer takes words from the buffer and presents them one bit at a time on the serial output. A pulse on the bit-enable input moves the output on to the next bit.

Words reach the memory side through a valid/ready stream that a DMA engine drains. A difference counter tracks how many disk words have not yet been taken by DMA. It raises a request once four of them are waiting.

The memory-side push stream carries DMA data in the to-disk direction. It also lets the controller queue status or header words. Software takes words one at a time with a read strobe; the popped word lands in a holding register.

Back-pressure rules:
- The push stream moves a word only on a cycle where `in_valid` and `in_ready` are both high.
- The DMA output stream moves a word only on a cycle where `dma_valid` and `dma_ready` are both high.
- The disk side cannot be stalled, so a word that arrives when the buffer is full is lost and flagged.

Top module: `sector_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `dma_req`=0, `overflow`=0, `underflow`=0, `ser_out`=0 and `rd_word`=0.
- R2: With `dir_to_disk`=0, each cycle with `bit_en`=1 shifts `ser_in` into a word, first bit being bit 15. On the 16th such cycle the completed word is written into the buffer, where it is visible from the next cycle.
- R3: With `dir_to_disk`=1, the serializer loads the head word on a cycle where it holds no bits, the buffer is not empty and `rd_strobe`=0. From the next cycle, `ser_out` shows bit 15 of that word. Each `bit_en` cycle then advances `ser_out` to the next lower bit. `ser_out` holds its value on cycles without `bit_en`, and it is 0 once all 16 bits have been shifted.
- R4: `in_ready` is 1 exactly when the buffer is not full and no disk word completes in that cycle. A word with `in_valid`=1 and `in_ready`=1 is appended.
- R5: All sources share one 256-word first-in first-out order. `full`=1 exactly when 256 words are held, and `empty`=1 exactly when none are held.
- R6: The difference counter rises by one for each disk word written and falls by one for each DMA pop, never going below zero. Push-stream writes and software reads leave it unchanged. `dma_req`=1 exactly while the counter is at least 4.
- R7: `dma_valid`=1 exactly when `dir_to_disk`=0, the buffer is not empty and `rd_strobe`=0. `dma_data` is the head word, and a handshake removes it.
- R8: `rd_strobe`=1 on a non-empty buffer removes the head word and places it in `rd_word` on the next cycle. A software read has priority over DMA and serializer pops.
- R9: A disk word completed while the buffer is full is dropped. The buffer contents stay unchanged, and `overflow` becomes 1 and stays 1 until reset.
- R10: Either of the following is an underflow: `rd_strobe` on an empty buffer, or `bit_en` in the to-disk direction while the serializer holds no bits. An underflow sets `underflow`, which stays 1 until reset, and leaves `rd_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_to_disk | input | 1 | 0: words come from disk; 1: words go to disk |
| bit_en | input | 1 | One serial bit time |
| ser_in | input | 1 | Serial data from disk |
| ser_out | output | 1 | Serial data toward disk |
| in_valid | input | 1 | Push stream word valid |
| in_ready | output | 1 | Push stream can accept |
| in_data | input | 16 | Push stream word |
| dma_valid | output | 1 | Head word offered to DMA |
| dma_ready | input | 1 | DMA takes the head word |
| dma_data | output | 16 | Head word |
| dma_req | output | 1 | At least four disk words await DMA |
| rd_strobe | input | 1 | Software read of one word |
| rd_word | output | 16 | Last word taken by software |
| full | output | 1 | 256 words held |
| empty | output | 1 | No words held |
| overflow | output | 1 | Sticky: disk word dropped |
| underflow | output | 1 | Sticky: read or serial bit with nothing available |

## Verification
The bench drives the threshold edge of the request: after three disk words `dma_req` must be low and after the fourth high. A counter that also counted push-stream words, or that ignored DMA pops, would assert or hold the request at the wrong time. It fills the buffer completely from the push stream and then completes a disk word. A design that wrapped its pointers or overwrote the oldest word would return a corrupted sequence when the 256 words are read back. Serial bit order, idle output after the last bit, software-read priority over a simultaneous DMA handshake, and both underflow paths are each exercised. A wrong bit order, a double pop, or an unflagged starved bit would each be caught.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int unsigned WORD_BITS = 16;
  localparam int unsigned BUF_WORDS = 256;
  localparam int unsigned REQ_LEVEL = 4;

  typedef enum logic {
    XFER_FROM_DISK = 1'b0,
    XFER_TO_DISK   = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);

  p_no_write_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  p_no_read_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
  p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en) |=> !empty);
  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: rtl/sfifo_serdes.sv
module sfifo_serdes #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         to_disk,
  input  logic         bit_en,
  input  logic         ser_in,
  input  logic         load,
  input  logic [W-1:0] load_word,
  output logic         word_done,
  output logic [W-1:0] word_out,
  output logic         ser_out,
  output logic         idle,
  output logic         starve
);
  localparam int unsigned BW = $clog2(W);
  localparam int unsigned LW = $clog2(W + 1);

  // collecting side
  logic [W-2:0]  in_sh;
  logic [BW-1:0] in_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_sh  <= '0;
      in_cnt <= '0;
    end else if (!to_disk && bit_en) begin
      in_sh  <= {in_sh[W-3:0], ser_in};
      in_cnt <= (in_cnt == BW'(W - 1)) ? '0 : in_cnt + 1'b1;
    end
  end

  assign word_done = !to_disk && bit_en && (in_cnt == BW'(W - 1));
  assign word_out  = {in_sh, ser_in};

  // emitting side
  logic [W-1:0]  out_sh;
  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_sh <= '0;
      left   <= '0;
    end else if (load) begin
      out_sh <= load_word;
      left   <= LW'(W);
    end else if (to_disk && bit_en && left != '0) begin
      out_sh <= {out_sh[W-2:0], 1'b0};
      left   <= left - 1'b1;
    end
  end

  assign idle    = (left == '0);
  assign ser_out = out_sh[W-1];
  assign starve  = to_disk && bit_en && idle;

  p_load_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> idle);
  p_ser_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !load) |=> $stable(ser_out));
  p_done_needs_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (bit_en && !to_disk));
endmodule

// File: rtl/sfifo_diffcnt.sv
module sfifo_diffcnt #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned LEVEL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic req
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] diff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      diff <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (diff != CW'(DEPTH)) diff <= diff + 1'b1;
        2'b01:   if (diff != '0) diff <= diff - 1'b1;
        default: diff <= diff;
      endcase
    end
  end

  assign req = (diff >= CW'(LEVEL));

  p_req_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(inc));
  p_req_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> $past(dec));
endmodule

// File: rtl/sector_fifo.sv
module sector_fifo
  import sfifo_pkg::*;
#(
  parameter int unsigned W     = WORD_BITS,
  parameter int unsigned DEPTH = BUF_WORDS,
  parameter int unsigned LEVEL = REQ_LEVEL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_to_disk,
  input  logic         bit_en,
  input  logic         ser_in,
  output logic         ser_out,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         dma_valid,
  input  logic         dma_ready,
  output logic [W-1:0] dma_data,
  output logic         dma_req,
  input  logic         rd_strobe,
  output logic [W-1:0] rd_word,
  output logic         full,
  output logic         empty,
  output logic         overflow,
  output logic         underflow
);
  xfer_dir_e    dir;
  logic         to_disk;
  logic         word_done, ser_idle, starve;
  logic [W-1:0] disk_word, head;
  logic         disk_push, in_fire, wr_en, sw_pop, ser_load, dma_pop, rd_en;
  logic [W-1:0] wr_data;

  assign dir     = xfer_dir_e'(dir_to_disk);
  assign to_disk = (dir == XFER_TO_DISK);

  sfifo_serdes #(.W(W)) u_serdes (
    .clk(clk), .rst_n(rst_n), .to_disk(to_disk), .bit_en(bit_en),
    .ser_in(ser_in), .load(ser_load), .load_word(head),
    .word_done(word_done), .word_out(disk_word), .ser_out(ser_out),
    .idle(ser_idle), .starve(starve)
  );

  assign disk_push = word_done && !full;
  assign in_ready  = !full && !word_done;
  assign in_fire   = in_valid && in_ready;
  assign wr_en     = disk_push || in_fire;
  assign wr_data   = word_done ? disk_word : in_data;

  assign sw_pop    = rd_strobe && !empty;
  assign ser_load  = to_disk && ser_idle && !empty && !rd_strobe;
  assign dma_valid = !to_disk && !empty && !rd_strobe;
  assign dma_pop   = dma_valid && dma_ready;
  assign rd_en     = sw_pop || ser_load || dma_pop;
  assign dma_data  = head;

  sfifo_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(head), .full(full), .empty(empty)
  );

  sfifo_diffcnt #(.DEPTH(DEPTH), .LEVEL(LEVEL)) u_diff (
    .clk(clk), .rst_n(rst_n), .inc(disk_push), .dec(dma_pop), .req(dma_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_word   <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (sw_pop) rd_word <= head;
      if (word_done && full) overflow <= 1'b1;
      if ((rd_strobe && empty) || starve) underflow <= 1'b1;
    end
  end

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  p_dma_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_ready) |=> $stable(dma_data));
  p_rd_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_word));
endmodule

// File: tb/sector_fifo_bench.sv
module sector_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_to_disk = 1'b0, bit_en = 1'b0, ser_in = 1'b0;
  logic        in_valid = 1'b0, dma_ready = 1'b0, rd_strobe = 1'b0;
  logic [15:0] in_data = '0;
  logic        ser_out, in_ready, dma_valid, dma_req, full, empty, overflow, underflow;
  logic [15:0] dma_data, rd_word;

  int unsigned checks = 0, fails = 0;
  logic [15:0] mq[$];
  int          diff = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  sector_fifo u_sector_fifo (
    .clk(clk), .rst_n(rst_n), .dir_to_disk(dir_to_disk), .bit_en(bit_en),
    .ser_in(ser_in), .ser_out(ser_out), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_data(dma_data), .dma_req(dma_req), .rd_strobe(rd_strobe),
    .rd_word(rd_word), .full(full), .empty(empty), .overflow(overflow),
    .underflow(underflow)
  );

  function automatic bit req_expected(int d);
    return d >= 4;
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(bit to_disk);
    rst_n = 1'b0;
    dir_to_disk = to_disk;
    cyc();
    cyc();
    rst_n = 1'b1;
    mq.delete();
    diff = 0;
  endtask

  task automatic send_word(logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      ser_in = w[i];
      bit_en = 1'b1;
      cyc();
      bit_en = 1'b0;
      if ($urandom_range(0, 2) == 0) cyc();
    end
  endtask

  task automatic push_in(logic [15:0] w);
    in_valid = 1'b1;
    in_data  = w;
    cyc();
    in_valid = 1'b0;
    mq.push_back(w);
  endtask

  task automatic shift_out_check(logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      check(ser_out == w[i], "R3 serial bit", {15'd0, ser_out}, {15'd0, w[i]});
      if ($urandom_range(0, 1) == 0) begin
        cyc();
        check(ser_out == w[i], "R3 hold without bit_en", {15'd0, ser_out}, {15'd0, w[i]});
      end
      bit_en = 1'b1;
      cyc();
      bit_en = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w, a, b;
    void'($urandom(32'h5EC7));
    @(negedge clk);
    do_reset(1'b0);

    // R1 reset state
    check(empty == 1 && full == 0, "R1 flags", {14'd0, full, empty}, 16'h0001);
    check(dma_req == 0 && overflow == 0 && underflow == 0, "R1 status",
          {13'd0, dma_req, overflow, underflow}, 16'h0000);
    check(ser_out == 0 && rd_word == 0, "R1 outputs", rd_word, 16'h0000);

    // R2 deserializer, R6 threshold
    a = 16'hA53C;
    send_word(a);
    mq.push_back(a); diff++;
    check(!empty && dma_data == a, "R2 assembled word", dma_data, a);
    check(dma_valid == 1, "R7 valid when data", {15'd0, dma_valid}, 16'h0001);
    for (int k = 0; k < 2; k++) begin
      w = 16'($urandom);
      send_word(w);
      mq.push_back(w); diff++;
    end
    check(dma_req == 0, "R6 below threshold at 3", {15'd0, dma_req}, 16'h0000);
    w = 16'($urandom);
    send_word(w);
    mq.push_back(w); diff++;
    check(dma_req == 1, "R6 request at 4", {15'd0, dma_req}, 16'h0001);
    check(dma_data == a, "R2 head unchanged", dma_data, a);

    // R7 DMA pop decrements
    dma_ready = 1'b1;
    cyc();
    dma_ready = 1'b0;
    void'(mq.pop_front()); diff--;
    check(dma_req == 0, "R6 DMA pop lowers count", {15'd0, dma_req}, 16'h0000);
    check(dma_data == mq[0], "R7 next head", dma_data, mq[0]);

    // R4/R6 push-stream word does not count
    check(in_ready == 1, "R4 ready when room", {15'd0, in_ready}, 16'h0001);
    push_in(16'h0BAD);
    check(dma_req == 0, "R6 push stream not counted", {15'd0, dma_req}, 16'h0000);

    // R8 software read wins over DMA
    b = mq[0];
    rd_strobe = 1'b1;
    dma_ready = 1'b1;
    #1;
    check(dma_valid == 0, "R7 valid low during read", {15'd0, dma_valid}, 16'h0000);
    cyc();
    rd_strobe = 1'b0;
    dma_ready = 1'b0;
    void'(mq.pop_front());
    check(rd_word == b, "R8 read word", rd_word, b);
    check(dma_data == mq[0], "R8 only one pop", dma_data, mq[0]);
    check(dma_req == 0, "R6 read not counted", {15'd0, dma_req}, 16'h0000);

    // drain through DMA, order (R5)
    while (mq.size() > 0) begin
      check(dma_data == mq[0], "R5 order via DMA", dma_data, mq[0]);
      dma_ready = 1'b1;
      cyc();
      dma_ready = 1'b0;
      void'(mq.pop_front());
    end
    check(empty == 1, "R5 empty after drain", {15'd0, empty}, 16'h0001);

    // R10 read on empty
    w = rd_word;
    rd_strobe = 1'b1;
    cyc();
    rd_strobe = 1'b0;
    check(underflow == 1, "R10 read empty flagged", {15'd0, underflow}, 16'h0001);
    check(rd_word == w, "R10 rd_word unchanged", rd_word, w);

    // R5/R4/R9 full buffer
    do_reset(1'b0);
    while (mq.size() < 256) begin
      in_valid = ($urandom_range(0, 3) != 0);
      in_data  = 16'($urandom);
      if (in_valid && !in_ready) begin
        check(0, "R4 ready before full", {15'd0, in_ready}, 16'h0001);
      end
      if (in_valid) mq.push_back(in_data);
      cyc();
    end
    in_valid = 1'b0;
    check(full == 1 && empty == 0, "R5 full at 256", {14'd0, full, empty}, 16'h0002);
    check(in_ready == 0, "R4 not ready when full", {15'd0, in_ready}, 16'h0000);
    in_valid = 1'b1;
    in_data  = 16'hDEAD;
    cyc();
    in_valid = 1'b0;
    send_word(16'hBEEF);
    check(overflow == 1, "R9 overflow flagged", {15'd0, overflow}, 16'h0001);
    check(full == 1, "R9 still full", {15'd0, full}, 16'h0001);
    check(dma_req == 0, "R9 dropped word not counted", {15'd0, dma_req}, 16'h0000);
    while (mq.size() > 0) begin
      rd_strobe = 1'b1;
      cyc();
      rd_strobe = 1'b0;
      w = mq.pop_front();
      check(rd_word == w, "R9 contents intact", rd_word, w);
    end
    check(empty == 1, "R9 no extra word", {15'd0, empty}, 16'h0001);

    // R3 serializer
    do_reset(1'b1);
    a = 16'hC3A5;
    b = 16'($urandom);
    push_in(a);
    push_in(b);
    check(dma_valid == 0, "R7 no DMA in to-disk", {15'd0, dma_valid}, 16'h0000);
    cyc();
    shift_out_check(a);
    check(ser_out == 0, "R3 idle zero", {15'd0, ser_out}, 16'h0000);
    cyc();
    shift_out_check(b);
    check(ser_out == 0 && empty == 1, "R3 idle after last", {14'd0, ser_out, empty}, 16'h0001);
    check(underflow == 0, "R10 no starve yet", {15'd0, underflow}, 16'h0000);
    bit_en = 1'b1;
    cyc();
    bit_en = 1'b0;
    check(underflow == 1, "R10 starved bit", {15'd0, underflow}, 16'h0001);

    // random mixed from-disk traffic
    do_reset(1'b0);
    for (int k = 0; k < 24; k++) begin
      w = 16'($urandom);
      send_word(w);
      mq.push_back(w); diff++;
      check(dma_req == req_expected(diff), "R6 random level", {15'd0, dma_req},
            {15'd0, req_expected(diff)});
      if ($urandom_range(0, 1) == 0) begin
        check(dma_data == mq[0], "R2 random head", dma_data, mq[0]);
        dma_ready = 1'b1;
        cyc();
        dma_ready = 1'b0;
        void'(mq.pop_front());
        if (diff > 0) diff--;
        check(dma_req == req_expected(diff), "R6 random after pop", {15'd0, dma_req},
              {15'd0, req_expected(diff)});
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule